// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the lookup stage of a first-level data cache whose set is chosen from the untranslated part of the address. The core sends only the page-offset part of the virtual address, in 8-byte words. The block registers the set and word position at once, so the tag and line storage for that set is already selected while the translation unit works on the upper address bits. In the next cycle the translation unit returns the physical frame number, a valid flag and a fault flag. Every way of the chosen set compares its stored tag against the physical tag in parallel. The one-hot hit vector then steers an N-to-1 multiplexer that returns the 64-bit word.

On a miss the block leaves the lookup state, raises a line-fill request carrying the physical line address, and waits for the whole line on the refill port. It writes that line into the way picked by a per-set binary-tree pseudo-LRU and marks the way valid. The core then reissues the access. Both hits and fills update the tree. A synchronous flush drops every line and clears every tree. The controller has two states. LOOKUP is the normal state. REFILL is entered on the transition *miss* and left either on *line installed* (refill arrives) or on *flush*.

Top module: `vipt_lookup`

## Requirements
- R1: The set is taken from word-address bits [8:3] (virtual byte-address bits [11:6]) and the word from bits [2:0]. The physical tag is the frame number together with any page-offset bits above the index. Elaboration stops with an error when index width plus line-offset width exceeds the page-offset width. So the same frame number with a different set index is a different line.
- R2: After reset no line is valid and every tree is zero. `req_ready` is 1, and `miss_req` and `rsp_valid` are 0.
- R3: A request accepted in cycle t produces its result in the first cycle ≥ t+1 in which `xlat_valid` is 1. In that cycle `rsp_valid` is 1, and `rsp_hit` is 1 exactly when a valid way of the set holds the physical tag.
- R4: On a hit, `rsp_data` is word w of the stored line, taken from line bits [64w+63:64w].
- R5: A lookup that is neither a hit nor a fault gives `rsp_miss` for that one cycle. From the next cycle `miss_req` is 1 with `miss_addr` = {frame number, set index} held stable and `req_ready` 0, until `refill_valid` is seen.
- R6: The refill line goes into the victim way of the missed set and becomes valid. The victim is found by walking the tree from node 0: a node bit of 0 goes to the lower half, a 1 goes to the upper half, node n has children 2n+1 and 2n+2, and the first bit walked is the way number's MSB. After the fill, `miss_req` drops and `req_ready` returns to 1.
- R7: A hit or a fill to way w sets each node on w's path to the inverse of w's bit at that level.
- R8: A translation fault gives `rsp_fault` with neither hit nor miss. It changes no line or tree, and no `miss_req` follows.
- R9: `flush` invalidates every line, zeroes the trees, drops any pending lookup and returns to LOOKUP, also in the middle of a refill.
- R10: While an accepted lookup waits for `xlat_valid`, `req_ready` is 0 and `rsp_valid` is 0.
- R11: In any cycle at most one way hits, and `rsp_valid` comes with exactly one of hit, miss or fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous invalidate-all |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_word_addr | input | 9 | Page-offset part of the virtual address, in 8-byte words |
| xlat_valid | input | 1 | Translation result present |
| xlat_pfn | input | 20 | Physical frame number |
| xlat_fault | input | 1 | Translation fault |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_fault | output | 1 | Lookup ended in translation fault |
| rsp_data | output | 64 | Hit word, zero otherwise |
| miss_req | output | 1 | Line fill requested |
| miss_addr | output | 26 | Physical line address of the fill |
| refill_valid | input | 1 | Refill line present |
| refill_line | input | 512 | Full line to install |

## Verification
The result of a request is due in the first cycle after acceptance in which translation is valid. The bench drives the frame number just after a falling edge and samples the response 1 ns later, before the edge that commits it. `miss_req` and `miss_addr` are due one edge after the miss response, and they are checked in each later cycle until the refill is driven. The effect of a fill or a flush is checked one edge after it, through `req_ready` and `miss_req`. The bench also checks it through the hit or miss of later lookups, which a behavioural model of the sets and trees predicts, including which line an eviction removed.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [0:0] {
        LK_LOOKUP,
        LK_REFILL
    } lk_state_e;
endpackage

// File: rtl/vipt_plru.sv
module vipt_plru #(
    parameter int WAYS = 8,
    parameter int SETS = 64,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] look_set,
    output logic [WAY_W-1:0] victim
);
    // node n holds bit n; bit WAYS-1 is spare
    logic [WAYS-1:0] tree_q [SETS];
    logic [WAYS-1:0] row_upd;

    always_comb begin
        logic [WAY_W-1:0] node;
        logic             b;
        node   = '0;
        victim = '0;
        for (int l = 0; l < WAY_W; l++) begin
            b = tree_q[look_set][node];
            victim[WAY_W-1-l] = b;
            node = WAY_W'(2 * 32'(node) + 1 + 32'(b));
        end
    end

    always_comb begin
        logic [WAY_W-1:0] node;
        logic             b;
        node    = '0;
        row_upd = tree_q[touch_set];
        for (int l = 0; l < WAY_W; l++) begin
            b = touch_way[WAY_W-1-l];
            row_upd[node] = ~b;
            node = WAY_W'(2 * 32'(node) + 1 + 32'(b));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_set] <= row_upd;
        end
    end
endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
    parameter int WAYS   = 8,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 512,
    parameter int WORD_W = 64,
    localparam int WSEL_W = $clog2(LINE_W / WORD_W),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic [TAG_W-1:0]  way_tag  [WAYS],
    input  logic [WAYS-1:0]   way_vld,
    input  logic [LINE_W-1:0] way_line [WAYS],
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic [WSEL_W-1:0] wsel,
    output logic [WAYS-1:0]   hit_vec,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [WORD_W-1:0] rd_word
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = way_vld[g] && (way_tag[g] == cmp_tag);
    end

    assign hit = |hit_vec;

    // AND-OR multiplexer steered by the one-hot hit vector
    always_comb begin
        rd_word = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                rd_word = rd_word | way_line[w][32'(wsel) * WORD_W +: WORD_W];
                hit_way = hit_way | WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
#(
    parameter int PAGE_OFF_W   = 12,
    parameter int PA_W         = 32,
    parameter int LINE_BYTES_W = 6,
    parameter int IDX_W        = 6,
    parameter int WAYS         = 8,
    parameter int WORD_W       = 64,
    localparam int WB_W      = $clog2(WORD_W / 8),
    localparam int PO_WORD_W = PAGE_OFF_W - WB_W,
    localparam int PFN_W     = PA_W - PAGE_OFF_W,
    localparam int LA_W      = PA_W - LINE_BYTES_W,
    localparam int LINE_W    = 8 << LINE_BYTES_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PO_WORD_W-1:0] req_word_addr,
    input  logic                 xlat_valid,
    input  logic [PFN_W-1:0]     xlat_pfn,
    input  logic                 xlat_fault,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic                 rsp_fault,
    output logic [WORD_W-1:0]    rsp_data,
    output logic                 miss_req,
    output logic [LA_W-1:0]      miss_addr,
    input  logic                 refill_valid,
    input  logic [LINE_W-1:0]    refill_line
);
    localparam int TAG_W  = LA_W - IDX_W;
    localparam int SETS   = 1 << IDX_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int WSEL_W = LINE_BYTES_W - WB_W;

    if (IDX_W + LINE_BYTES_W > PAGE_OFF_W) begin : g_bad_index
        $error("set index and line offset must fit in the page offset");
    end
    if ((1 << WAY_W) != WAYS) begin : g_bad_ways
        $error("tree replacement needs a power-of-two way count");
    end

    lk_state_e state_q, state_d;

    logic                 s2_valid;
    logic [PO_WORD_W-1:0] s2_wa;
    logic [IDX_W-1:0]     s2_set;
    logic [WSEL_W-1:0]    s2_wsel;
    logic [LA_W-1:0]      line_addr;
    logic [LA_W-1:0]      miss_addr_q;
    logic [IDX_W-1:0]     fill_set;

    logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
    logic [LINE_W-1:0] data_mem [SETS][WAYS];
    logic [WAYS-1:0]   valid_mem [SETS];

    logic [WAYS-1:0]   hit_vec;
    logic              any_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WORD_W-1:0] rd_word;
    logic [WAY_W-1:0]  victim;
    logic [IDX_W-1:0]  plru_look_set;
    logic              done, do_fill;

    assign s2_set    = s2_wa[IDX_W+WSEL_W-1:WSEL_W];
    assign s2_wsel   = s2_wa[WSEL_W-1:0];
    assign line_addr = {xlat_pfn, s2_wa[PO_WORD_W-1:WSEL_W]};
    assign fill_set  = miss_addr_q[IDX_W-1:0];
    assign done      = (state_q == LK_LOOKUP) && s2_valid && xlat_valid;
    assign do_fill   = (state_q == LK_REFILL) && refill_valid && !flush;
    assign plru_look_set = (state_q == LK_REFILL) ? fill_set : s2_set;

    vipt_way_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
    ) u_match (
        .way_tag (tag_mem[s2_set]),
        .way_vld (valid_mem[s2_set]),
        .way_line(data_mem[s2_set]),
        .cmp_tag (line_addr[LA_W-1:IDX_W]),
        .wsel    (s2_wsel),
        .hit_vec (hit_vec),
        .hit     (any_hit),
        .hit_way (hit_way),
        .rd_word (rd_word)
    );

    vipt_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
        .clk      (clk),
        .rst      (rst),
        .clr      (flush),
        .touch_en (rsp_hit || do_fill),
        .touch_set(do_fill ? fill_set : s2_set),
        .touch_way(do_fill ? victim : hit_way),
        .look_set (plru_look_set),
        .victim   (victim)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst || flush) state_q <= LK_LOOKUP;
        else              state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOOKUP: if (rsp_miss)     state_d = LK_REFILL;
            LK_REFILL: if (refill_valid) state_d = LK_LOOKUP;
        endcase
    end

    // outputs
    always_comb begin
        rsp_valid = done;
        rsp_fault = done && xlat_fault;
        rsp_hit   = done && !xlat_fault && any_hit;
        rsp_miss  = done && !xlat_fault && !any_hit;
        rsp_data  = rsp_hit ? rd_word : '0;
        miss_req  = (state_q == LK_REFILL);
        miss_addr = miss_addr_q;
        req_ready = (state_q == LK_LOOKUP) && (!s2_valid || xlat_valid) && !rsp_miss;
    end

    // stage 1: capture the untranslated index and word position
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            s2_valid <= 1'b0;
        end else if (req_valid && req_ready) begin
            s2_valid <= 1'b1;
            s2_wa    <= req_word_addr;
        end else if (done) begin
            s2_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rsp_miss) miss_addr_q <= line_addr;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++) valid_mem[s] <= '0;
        end else if (do_fill) begin
            valid_mem[fill_set][victim] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_fill) begin
            tag_mem[fill_set][victim]  <= miss_addr_q[LA_W-1:IDX_W];
            data_mem[fill_set][victim] <= refill_line;
        end
    end
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
    parameter int WAYS = 8,
    parameter int LA_W = 26
) (
    input logic            clk,
    input logic            rst,
    input logic            flush,
    input logic            req_ready,
    input logic            xlat_valid,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic            miss_req,
    input logic [LA_W-1:0] miss_addr,
    input logic            refill_valid,
    input logic [WAYS-1:0] hit_vec
);
    assert_single_way_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

    assert_quiet_outcome_R11: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    assert_needs_xlat_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> xlat_valid);

    assert_miss_raises_req_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss && !flush) |=> miss_req);

    assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
        (miss_req && !refill_valid && !flush) |=> (miss_req && $stable(miss_addr)));

    assert_blocked_in_fill_R5: assert property (@(posedge clk) disable iff (rst)
        miss_req |-> !req_ready);

    assert_fill_ends_req_R6: assert property (@(posedge clk) disable iff (rst)
        (miss_req && refill_valid) |=> !miss_req);

    assert_fault_no_fill_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |=> !miss_req);

    assert_flush_idle_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !miss_req);
endmodule

bind vipt_lookup vipt_lookup_chk #(.WAYS(WAYS), .LA_W(LA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .req_ready   (req_ready),
    .xlat_valid  (xlat_valid),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_miss    (rsp_miss),
    .rsp_fault   (rsp_fault),
    .miss_req    (miss_req),
    .miss_addr   (miss_addr),
    .refill_valid(refill_valid),
    .hit_vec     (hit_vec)
);

// File: tb/vipt_lookup_test.sv
`timescale 1ns/1ps
module vipt_lookup_test;
    localparam int NSETS = 64;
    localparam int NWAYS = 8;
    localparam int LVL   = 3;

    logic         clk = 0;
    logic         rst = 1;
    logic         flush = 0;
    logic         req_valid = 0;
    logic         req_ready;
    logic [8:0]   req_word_addr = '0;
    logic         xlat_valid = 0;
    logic [19:0]  xlat_pfn = '0;
    logic         xlat_fault = 0;
    logic         rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [63:0]  rsp_data;
    logic         miss_req;
    logic [25:0]  miss_addr;
    logic         refill_valid = 0;
    logic [511:0] refill_line = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // behavioural model of the sets
    bit mv [NSETS][NWAYS];
    int mt [NSETS][NWAYS];
    bit mp [NSETS][NWAYS];

    always #4 clk = ~clk;

    vipt_lookup uut (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_word_addr(req_word_addr),
        .xlat_valid(xlat_valid), .xlat_pfn(xlat_pfn), .xlat_fault(xlat_fault),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_data(rsp_data),
        .miss_req(miss_req), .miss_addr(miss_addr),
        .refill_valid(refill_valid), .refill_line(refill_line)
    );

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] word_of(int pfn, int s, int w);
        return {32'(pfn * 64 + s), 32'(w * 7 + 1)};
    endfunction

    function automatic logic [511:0] line_of(int pfn, int s);
        logic [511:0] l;
        for (int w = 0; w < 8; w++) l[w*64 +: 64] = word_of(pfn, s, w);
        return l;
    endfunction

    function automatic int m_victim(int s);
        int node = 0;
        int way = 0;
        for (int l = 0; l < LVL; l++) begin
            int b = int'(mp[s][node]);
            way  = way * 2 + b;
            node = 2 * node + 1 + b;
        end
        return way;
    endfunction

    function automatic void m_touch(int s, int way);
        int node = 0;
        for (int l = 0; l < LVL; l++) begin
            int b = (way >> (LVL - 1 - l)) & 1;
            mp[s][node] = (b == 0);
            node = 2 * node + 1 + b;
        end
    endfunction

    function automatic void m_clear();
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NWAYS; w++) begin
                mv[s][w] = 0;
                mp[s][w] = 0;
            end
    endfunction

    // one lookup, with optional translation delay and optional flush during the fill
    task automatic op(int s, int w, int pfn, bit flt, int hold, bit abort);
        int way = -1;
        bit ehit;
        bit emiss;
        @(negedge clk);
        req_valid = 1;
        req_word_addr = 9'((s << 3) | w);
        #1 check("R10 ready for new request", req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < hold; i++) begin
            #1 check("R10 no result before translation", rsp_valid, 0);
            check("R10 ready low while waiting", req_ready, 0);
            @(negedge clk);
        end
        xlat_valid = 1;
        xlat_pfn = 20'(pfn);
        xlat_fault = flt;
        #1;
        for (int i = 0; i < NWAYS; i++) if (mv[s][i] && mt[s][i] == pfn) way = i;
        ehit  = !flt && way >= 0;
        emiss = !flt && way < 0;
        check("R3 result due", rsp_valid, 1);
        check("R3 hit flag", rsp_hit, ehit);
        check("R5 miss flag", rsp_miss, emiss);
        check("R8 fault flag", rsp_fault, flt);
        if (ehit) check("R4 hit word", rsp_data, word_of(pfn, s, w));
        check("R11 ready with result", req_ready, !emiss);
        if (ehit) m_touch(s, way);
        @(negedge clk);
        xlat_valid = 0;
        xlat_fault = 0;
        #1 check(flt ? "R8 no fill after fault" : "R5 fill request", miss_req, emiss);
        if (emiss) begin
            check("R5 line address", miss_addr, 64'({20'(pfn), 6'(s)}));
            check("R5 ready low in fill", req_ready, 0);
            @(negedge clk);
            #1 check("R5 request held", miss_req, 1);
            check("R5 address held", miss_addr, 64'({20'(pfn), 6'(s)}));
            if (abort) begin
                flush = 1;
                @(negedge clk);
                flush = 0;
                m_clear();
                #1 check("R9 flush ends fill", miss_req, 0);
                check("R9 ready after flush", req_ready, 1);
            end else begin
                int v = m_victim(s);
                refill_valid = 1;
                refill_line = line_of(pfn, s);
                @(negedge clk);
                refill_valid = 0;
                mv[s][v] = 1;
                mt[s][v] = pfn;
                m_touch(s, v);
                #1 check("R6 fill completes", miss_req, 0);
                check("R6 ready after fill", req_ready, 1);
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1;
        @(negedge clk);
        flush = 0;
        m_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned x = 32'h1234_5678;
        m_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        #1 check("R2 ready after reset", req_ready, 1);
        check("R2 no fill after reset", miss_req, 0);
        check("R2 no result after reset", rsp_valid, 0);

        // R2: cold miss, then R3/R4 hits on several words
        op(3, 0, 'h111, 0, 0, 0);
        op(3, 0, 'h111, 0, 0, 0);
        op(3, 5, 'h111, 0, 0, 0);
        op(3, 7, 'h111, 0, 0, 0);
        // R1: same frame, other set is a different line; same set, other frame too
        op(4, 2, 'h111, 0, 0, 0);
        op(3, 2, 'h222, 0, 0, 0);
        op(3, 2, 'h111, 0, 0, 0);
        // R8: fault on a present line, which still hits afterwards
        op(3, 1, 'h111, 1, 0, 0);
        op(3, 1, 'h111, 0, 0, 0);
        op(6, 1, 'h333, 1, 0, 0);
        // R10: translation arrives late
        op(3, 4, 'h111, 0, 3, 0);
        op(7, 4, 'h444, 0, 2, 0);
        // R6/R7: fill a set past its ways, touch some, evict
        for (int i = 0; i < 8; i++) op(9, i, 'h200 + i, 0, 0, 0);
        op(9, 0, 'h202, 0, 0, 0);
        op(9, 0, 'h205, 0, 0, 0);
        op(9, 3, 'h300, 0, 0, 0);
        for (int i = 0; i < 8; i++) op(9, 6, 'h200 + i, 0, 0, 0);
        // R9: flush drops lines
        do_flush();
        op(3, 0, 'h111, 0, 0, 0);
        op(3, 0, 'h111, 0, 0, 0);
        // R9: flush during a fill
        op(12, 0, 'h555, 0, 0, 1);
        op(3, 0, 'h111, 0, 0, 0);
        // mixed traffic over a small pool forcing evictions
        for (int k = 0; k < 400; k++) begin
            int s, pfn, w;
            bit flt;
            x = x * 32'd1103515245 + 32'd12345;
            s   = 9 + int'((x >> 8) % 2);
            pfn = 'h400 + int'((x >> 12) % 12);
            w   = int'((x >> 20) % 8);
            flt = ((x >> 26) % 16) == 0;
            op(s, w, pfn, flt, int'((x >> 28) % 3 == 0), 0);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule